// File: doc/BRIEF.md
# Cascadable Four-Channel Interval Timer Group

This block holds four down-counting interval timers, numbered 0 to 3, behind a flat 32-bit register bus. Writes complete in one clock. Reads are combinational from the address. Each timer has four word registers: a read-only current count, a base count that also carries a count-inhibit bit, and two words of plain storage for interrupt routing (vector/priority and destination). One group control register holds three fields:

- a clock-divide selection shared by all four timers;
- three cascade bits, each of which chains one pair of neighbouring timers;
- three rollover bits, one for each cascade pair.

An uncascaded timer counts prescaled ticks. It reloads from its base count each time it expires, so it fires periodically until software inhibits it. When cascade bit k is set, timer k becomes the low half of a pair and uses its whole 32-bit word as a count. Timer k+1 then counts the expirations of timer k rather than ticks. The inhibit bit of timer k+1 starts and stops the pair, and only timer k+1 raises the interrupt. Each timer drives its own active-low interrupt output.

Top module: `intv_timer_grp`

## Requirements
- R1: After reset, every base-count register reads 0x80000000 (inhibited), every other register reads 0, and irq_n is 4'hF.
- R2: Address map. Timer n occupies byte addresses n*0x40 to n*0x40+0x3F, with current count at +0x00, base count at +0x10, vector/priority at +0x20 and destination at +0x30. Address bits 3:0 are ignored. Vector/priority and destination are plain 32-bit storage. The current count is read-only, and writes to it are ignored. Group control is at 0x100 and reads back only bits 26:24, 9:8 and 2:0, with all other bits zero. Any other address in 0x100 to 0x1FF reads zero.
- R3: The prescaler emits one tick every 8 << D clocks, where D is control bits 9:8.
- R4: An uncascaded timer with base bits 30:0 equal to B expires every max(B,1) ticks. On expiry it reloads B into current bits 30:0 and inverts current bit 31.
- R5: On expiry, irq_n[i] goes low for exactly one tick period (8 << D clocks) and repeats every period. With B of 0 or 1 the output stays low continuously.
- R6: While a timer's base bit 31 is set, its current count does not change and its irq_n stays high.
- R7: A write to a base-count register also loads the current count. Current bits 30:0 take the written bits 30:0 and current bit 31 is cleared. For the low half of a pair, all 32 bits are copied.
- R8: Control bit k (k = 0..2) chains timer k and timer k+1. Timer k counts ticks over its full 32-bit current word, ignores its own bit 31 as an inhibit, and runs while timer k+1 is not inhibited. Timer k+1 decrements once per expiry of timer k. The pair's period is L*U ticks, where L is timer k's base and U is timer k+1's base.
- R9: While its cascade bit is set, the low half of a pair never drives its irq_n low.
- R10: Control bit 24+k selects rollover for pair k. After an expiry of timer k, timer k reloads 0xFFFFFFFF instead of its base, except when timer k+1 expires in the same tick.
- R11: The largest uncascaded base value, 0x7FFFFFFF, loads exactly and counts down one per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 9 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_n | output | 4 | Active-low interrupt, one per timer |

## Verification
The hardest state to reach is a chained pair after its first low-half expiry. With rollover set, the low half reloads all-ones, so the pair's next interrupt lies about 2^32 ticks away and cannot be waited for. The bench therefore starts the pair with a tiny remainder and reads back both current counts a few ticks later. It expects the low half to sit just under 0xFFFFFFFF and the high half to have dropped by exactly one. The full-width count of the low half is covered the same way: the bench loads it with bit 31 set and confirms that it still counts.

// File: rtl/intv_timer_grp.sv
module intv_timer_grp #(
  parameter int PRE_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [8:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  irq_n
);
  localparam int NT = 4;
  localparam int PW = PRE_SHIFT + 3;
  localparam logic [31:0] INH = 32'h8000_0000;

  logic [NT-1:0][31:0] cur_q, base_q, vp_q, dst_q, rl;
  logic [2:0]          casc_q, rovr_q;
  logic [1:0]          div_q;
  logic [PW-1:0]       pre_q, pre_lim;
  logic                tick, is_ctrl, is_tmr;
  logic [1:0]          sel_t, sel_r;
  logic [NT-1:0]       lower, run, ev, expd, base_wr, irq_q, casc_sh;

  assign lower   = {1'b0, casc_q};
  assign casc_sh = {casc_q, 1'b0};
  assign pre_lim = PW'((32'd1 << (32'(PRE_SHIFT) + 32'(div_q))) - 32'd1);
  assign tick    = (pre_q >= pre_lim);
  assign sel_t   = addr[7:6];
  assign sel_r   = addr[5:4];
  assign is_tmr  = !addr[8];
  assign is_ctrl = addr[8] && (addr[7:4] == 4'd0);
  assign irq_n   = ~irq_q;

  always_comb begin
    logic          e_prev;
    logic [NT:0]   ex_ext;
    logic [NT:0]   rv_ext;
    run[NT-1] = !base_q[NT-1][31];
    for (int i = NT - 2; i >= 0; i--)
      run[i] = lower[i] ? run[i+1] : !base_q[i][31];
    e_prev = 1'b0;
    for (int i = 0; i < NT; i++) begin
      base_wr[i] = wr_en && is_tmr && (sel_t == 2'(i)) && (sel_r == 2'd1);
      ev[i]      = casc_sh[i] ? e_prev : tick;
      expd[i]    = ev[i] && run[i] &&
                   (lower[i] ? (cur_q[i] <= 32'd1) : (cur_q[i][30:0] <= 31'd1));
      e_prev     = expd[i];
    end
    ex_ext = {1'b0, expd};
    rv_ext = {2'b0, rovr_q};
    for (int i = 0; i < NT; i++) begin
      if (lower[i])
        rl[i] = (rv_ext[i] && !ex_ext[i+1]) ? 32'hFFFF_FFFF : base_q[i];
      else
        rl[i] = {~cur_q[i][31], base_q[i][30:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      casc_q <= '0;
      rovr_q <= '0;
      div_q  <= '0;
      cur_q  <= '0;
      base_q <= {NT{INH}};
      vp_q   <= '0;
      dst_q  <= '0;
      irq_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (wr_en && is_ctrl) begin
        casc_q <= wdata[2:0];
        div_q  <= wdata[9:8];
        rovr_q <= wdata[26:24];
      end
      for (int i = 0; i < NT; i++) begin
        if (wr_en && is_tmr && sel_t == 2'(i) && sel_r == 2'd2) vp_q[i]  <= wdata;
        if (wr_en && is_tmr && sel_t == 2'(i) && sel_r == 2'd3) dst_q[i] <= wdata;
        if (base_wr[i]) begin
          base_q[i] <= wdata;
          cur_q[i]  <= lower[i] ? wdata : {1'b0, wdata[30:0]};
        end else if (expd[i]) begin
          cur_q[i] <= rl[i];
        end else if (ev[i] && run[i]) begin
          cur_q[i] <= lower[i] ? cur_q[i] - 32'd1
                               : {cur_q[i][31], cur_q[i][30:0] - 31'd1};
        end
        if (expd[i] && !lower[i]) irq_q[i] <= 1'b1;
        else if (tick)            irq_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (is_ctrl)
      rdata = {5'd0, rovr_q, 14'd0, div_q, 5'd0, casc_q};
    else if (is_tmr)
      case (sel_r)
        2'd0:    rdata = cur_q[sel_t];
        2'd1:    rdata = base_q[sel_t];
        2'd2:    rdata = vp_q[sel_t];
        default: rdata = dst_q[sel_t];
      endcase
  end
endmodule

// File: rtl/intv_timer_grp_chk.sv
module intv_timer_grp_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [8:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             tick,
  input logic [3:0]       run,
  input logic [3:0]       base_wr,
  input logic [3:0]       irq_n,
  input logic [3:0][31:0] cur_q
);
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    addr[8] |-> ((rdata & ~32'h0700_0307) == 32'd0));

  for (genvar i = 0; i < 4; i++) begin : g_t
    a_r6_inhibit_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !base_wr[i]) |=> $stable(cur_q[i]));

    a_r7_base_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr[i] |=> (cur_q[i][30:0] == $past(wdata[30:0])));

    a_r5_irq_falls_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n[i]) |-> $past(tick));

    a_r5_irq_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n[i]) |-> $past(tick));
  end
endmodule

bind intv_timer_grp intv_timer_grp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
  .tick(tick), .run(run), .base_wr(base_wr), .irq_n(irq_n), .cur_q(cur_q)
);

// File: tb/intv_timer_grp_tb.sv
module intv_timer_grp_tb;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_n;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  localparam logic [8:0] CTRL = 9'h100;
  localparam int VEC [5][3] = '{'{0,0,5}, '{1,1,3}, '{2,2,2}, '{3,3,2}, '{2,0,7}};

  always #5 clk = ~clk;

  intv_timer_grp u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  function automatic logic [8:0] ta(int t, int r);
    return 9'(t * 64 + r * 16);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, logic [31:0] act, logic [31:0] lo, logic [31:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_fall(int t);
    logic prev;
    prev = irq_n[t];
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (prev && !irq_n[t]) return;
      prev = irq_n[t];
    end
  endtask

  task automatic measure(int t, output int per, output int low, output bit oth);
    bit seen;
    per = -1; low = 1; oth = 1'b0; seen = 1'b0;
    wait_fall(t);
    for (int n = 1; n < 4000; n++) begin
      @(negedge clk);
      if ((irq_n | (4'b1 << t)) != 4'hF) oth = 1'b1;
      if (irq_n[t]) seen = 1'b1;
      else if (!seen) low++;
      else begin per = n; return; end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int per, low, cnt, t, dv, b;
    bit oth;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      rd(ta(i, 1), d); chk("R1 base reset", d, 32'h8000_0000);
    end
    rd(ta(0, 0), d); chk("R1 cur reset", d, 0);
    rd(ta(3, 2), d); chk("R1 vp reset", d, 0);
    rd(CTRL, d);     chk("R1 ctrl reset", d, 0);
    chk("R1 irq reset", 32'(irq_n), 32'hF);

    wr(ta(1, 2), 32'h1234_5678); rd(ta(1, 2), d); chk("R2 vp storage", d, 32'h1234_5678);
    wr(ta(2, 3), 32'hA5A5_0F0F); rd(ta(2, 3), d); chk("R2 dest storage", d, 32'hA5A5_0F0F);
    wr(CTRL, 32'hFFFF_FFFF);     rd(CTRL, d);     chk("R2 ctrl reserved", d, 32'h0700_0307);
    wr(CTRL, 32'h0);
    rd(9'h140, d); chk("R2 unmapped", d, 0);
    wr(ta(0, 0), 32'hDEAD_BEEF); rd(ta(0, 0), d); chk("R2 cur read-only", d, 0);

    wr(ta(0, 1), 32'h8000_0123); rd(ta(0, 0), d); chk("R7 load while inhibited", d, 32'h123);
    cnt = 0;
    repeat (200) begin @(negedge clk); if (!irq_n[0]) cnt++; end
    rd(ta(0, 0), d); chk("R6 inhibited count frozen", d, 32'h123);
    chk("R6 inhibited no irq", cnt, 0);

    for (int v = 0; v < 5; v++) begin
      t = VEC[v][0]; dv = VEC[v][1]; b = VEC[v][2];
      wr(CTRL, 32'(dv) << 8);
      wr(ta(t, 1), 32'(b));
      measure(t, per, low, oth);
      chk($sformatf("R3 R4 period t%0d div%0d", t, dv), per, 32'(b * (8 << dv)));
      chk($sformatf("R5 low width t%0d", t), low, 32'(8 << dv));
      chk($sformatf("R5 only t%0d fires", t), 32'(oth), 0);
      wr(ta(t, 1), 32'h8000_0000 | 32'(b));
      repeat (150) @(negedge clk);
    end

    wr(CTRL, 32'h0);
    wr(ta(0, 1), 32'd3);
    wait_fall(0);
    rd(ta(0, 0), d); chk("R4 toggle on first expiry", d, 32'h8000_0003);
    wait_fall(0);
    rd(ta(0, 0), d); chk("R4 toggle on second expiry", d, 32'h0000_0003);
    wait_fall(0);
    wr(ta(0, 1), 32'd3);
    rd(ta(0, 0), d); chk("R7 write clears toggle", d, 32'h0000_0003);

    wr(ta(0, 1), 32'd1);
    repeat (30) @(negedge clk);
    cnt = 0;
    repeat (64) begin @(negedge clk); if (!irq_n[0]) cnt++; end
    chk("R5 base one held low", cnt, 64);
    wr(ta(0, 1), 32'h8000_0001);
    repeat (20) @(negedge clk);
    chk("R6 stop releases irq", 32'(irq_n[0]), 1);

    wr(CTRL, 32'h1);
    wr(ta(0, 1), 32'h8000_0002);
    rd(ta(0, 0), d); chk("R8 low half full width load", d, 32'h8000_0002);
    wr(ta(1, 1), 32'd2);
    repeat (40) @(negedge clk);
    rd(ta(0, 0), d); chk_rng("R8 low half counts despite bit31", d, 32'h7FFF_FFFC, 32'h8000_0001);
    wr(ta(1, 1), 32'h8000_0002);
    wr(ta(0, 1), 32'd3);
    wr(ta(1, 1), 32'd2);
    measure(1, per, low, oth);
    chk("R8 pair period", per, 48);
    chk("R5 pair low width", low, 8);
    chk("R9 low half quiet", 32'(oth), 0);
    wr(ta(1, 1), 32'h8000_0002);
    wr(ta(0, 1), 32'h8000_0000);
    repeat (20) @(negedge clk);

    wr(CTRL, 32'h0100_0001);
    wr(ta(0, 1), 32'd3);
    wr(ta(1, 1), 32'd2);
    repeat (60) @(negedge clk);
    rd(ta(0, 0), d); chk_rng("R10 rollover reload", d, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
    rd(ta(1, 0), d); chk("R8 R10 upper counted one", d, 32'h1);
    wr(ta(1, 1), 32'h8000_0002);
    wr(ta(0, 1), 32'h8000_0000);
    wr(CTRL, 32'h0);
    repeat (20) @(negedge clk);

    wr(ta(2, 1), 32'h7FFF_FFFF);
    rd(ta(2, 0), d); chk("R11 max load", d, 32'h7FFF_FFFF);
    repeat (80) @(negedge clk);
    rd(ta(2, 0), d); chk_rng("R11 max counts down", d, 32'h7FFF_FFF4, 32'h7FFF_FFF6);
    chk("R11 no irq yet", 32'(irq_n[2]), 1);
    wr(ta(2, 1), 32'hFFFF_FFFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule